// File: doc/BRIEF.md
# Vectored Interrupt Controller with Per-Input Polarity and Trigger Mode

This block gathers up to 32 asynchronous interrupt lines and turns them into two request outputs, one critical and one normal, together with a vector code that names the most urgent pending line. Each line has its own configuration. One bit sets the active level, one bit selects level or edge detection, one bit selects the request output, and one bit enables the line. Every line passes through a two-flop synchroniser before its polarity is applied and its edges are detected.

Software reaches the block through a single-cycle register port with one address. A write takes effect at the next clock edge, and a read returns the addressed register in the same cycle. Status bits are cleared by writing ones. In all 32-bit registers, input 0 sits in the most significant bit. Fixed priority gives input 0 precedence over every other input. The vector code is a programmable base plus the index of the winning input, so the interrupt service code can use it directly as a table slot.

Top module: `ivc_top`

## Requirements
- R1: After reset, status, enable, critical-select, trigger and vector-base read as zero, polarity reads as all ones, and both request outputs and `vec_valid` are low.
- R2: Register addresses are status=0, enable=1, critical-select=2, polarity=3, trigger=4 and vector-base=5, with the base in the low bits. In every per-input register, input i occupies bit 31-i.
- R3: A polarity bit of 1 makes its input active when high. A polarity bit of 0 makes it active when low.
- R4: With its trigger bit at 0 (level mode), a status bit equals the active state of its input three clock edges after the pin changes. A write-one-clear issued while the input is still active has no lasting effect.
- R5: With its trigger bit at 1 (edge mode), a status bit is set by an inactive-to-active transition and remains set after the input returns to inactive. Writing 1 to that bit clears it, writing 0 leaves it set, and an input held steadily active does not set it again.
- R6: A request output is driven only by inputs whose status and enable bits are both 1. With enable at zero, no request is raised, but status still records activity.
- R7: A pending enabled input whose critical-select bit is 1 raises `irq_crit`. One whose bit is 0 raises `irq_norm`.
- R8: `vec_valid` equals `irq_crit` OR `irq_norm`. While it is high, `vec_code` is the vector base plus the lowest index among pending enabled inputs, whatever their routing.
- R9: Addresses 6 and 7 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Interrupt lines, bit i is input i, asynchronous |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_crit | output | 1 | Critical request |
| irq_norm | output | 1 | Non-critical request |
| vec_valid | output | 1 | A request is active and `vec_code` is meaningful |
| vec_code | output | 8 | Vector base plus index of the winning input |

## Verification
A status bit that is wrong inside the block shows at the ports in two places. The status register reads back with the wrong bit set or clear. In the same cycle, the request and vector outputs follow that wrong bit, because they are combinational from the stored status. A wrong synchroniser or edge register instead shows as a status update that arrives one edge early or late compared with the fixed three-edge latency, so the bench samples at that exact cycle and also one cycle before it. A wrong priority or routing decision appears at once as a wrong `vec_code` or a wrong request output whenever two or more inputs are pending.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

    typedef enum logic [2:0] {
        RA_STATUS = 3'd0,
        RA_ENABLE = 3'd1,
        RA_CRIT   = 3'd2,
        RA_POL    = 3'd3,
        RA_TRIG   = 3'd4,
        RA_VBASE  = 3'd5
    } ivc_addr_e;

    typedef struct packed {
        logic       valid;
        logic [4:0] idx;
    } ivc_win_t;

    function automatic int unsigned reg_pos(input int unsigned inp, input int unsigned width);
        return width - 1 - inp;
    endfunction

endpackage

// File: rtl/ivc_input_stage.sv
module ivc_input_stage #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin,
    input  logic [N-1:0] pol_hi,
    output logic [N-1:0] active,
    output logic [N-1:0] rise
);
    logic [N-1:0] meta_q;
    logic [N-1:0] sync_q;
    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q[i] <= 1'b0;
                sync_q[i] <= 1'b0;
                prev_q[i] <= 1'b0;
            end else begin
                meta_q[i] <= pin[i];
                sync_q[i] <= meta_q[i];
                prev_q[i] <= active[i];
            end
        end
        assign active[i] = pol_hi[i] ? sync_q[i] : ~sync_q[i];
        assign rise[i]   = active[i] & ~prev_q[i];
    end

endmodule

// File: rtl/ivc_status.sv
module ivc_status #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] active,
    input  logic [N-1:0] rise,
    input  logic [N-1:0] edge_mode,
    input  logic [N-1:0] clr,
    output logic [N-1:0] status
);
    logic [N-1:0] st_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                st_q[i] <= 1'b0;
            end else if (edge_mode[i]) begin
                st_q[i] <= (st_q[i] & ~clr[i]) | rise[i];
            end else begin
                st_q[i] <= active[i];
            end
        end
    end

    assign status = st_q;

    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(st_q) & $past(edge_mode) & ~$past(clr) & ~st_q) == '0)); // R5

    AST_LEVEL_NO_STICK: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(~edge_mode) & ~$past(active) & st_q) == '0)); // R4

endmodule

// File: rtl/ivc_regfile.sv
module ivc_regfile
    import ivc_pkg::*;
#(
    parameter int N  = 32,
    parameter int VW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    addr,
    input  logic          we,
    input  logic [N-1:0]  wdata,
    output logic [N-1:0]  rdata,
    input  logic [N-1:0]  status_io,
    output logic [N-1:0]  clr_io,
    output logic [N-1:0]  en_io,
    output logic [N-1:0]  crit_io,
    output logic [N-1:0]  pol_io,
    output logic [N-1:0]  trig_io,
    output logic [VW-1:0] vbase
);
    logic [N-1:0]  en_q, crit_q, pol_q, trig_q;
    logic [VW-1:0] vbase_q;
    logic [N-1:0]  status_rv;
    ivc_addr_e     a;

    assign a = ivc_addr_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= '0;
            crit_q  <= '0;
            pol_q   <= '1;
            trig_q  <= '0;
            vbase_q <= '0;
        end else if (we) begin
            case (a)
                RA_ENABLE: en_q    <= wdata;
                RA_CRIT:   crit_q  <= wdata;
                RA_POL:    pol_q   <= wdata;
                RA_TRIG:   trig_q  <= wdata;
                RA_VBASE:  vbase_q <= wdata[VW-1:0];
                default:   ;
            endcase
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_swap
        localparam int P = reg_pos(i, N);
        assign en_io[i]     = en_q[P];
        assign crit_io[i]   = crit_q[P];
        assign pol_io[i]    = pol_q[P];
        assign trig_io[i]   = trig_q[P];
        assign status_rv[P] = status_io[i];
        assign clr_io[i]    = we && (a == RA_STATUS) && wdata[P];
    end

    assign vbase = vbase_q;

    always_comb begin
        rdata = '0;
        case (a)
            RA_STATUS: rdata = status_rv;
            RA_ENABLE: rdata = en_q;
            RA_CRIT:   rdata = crit_q;
            RA_POL:    rdata = pol_q;
            RA_TRIG:   rdata = trig_q;
            RA_VBASE:  rdata[VW-1:0] = vbase_q;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/ivc_prio.sv
module ivc_prio #(
    parameter int N  = 32,
    parameter int VW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      pend,
    input  logic [VW-1:0]     vbase,
    output logic              found,
    output logic [$clog2(N)-1:0] win_idx,
    output logic [VW-1:0]     vec
);
    localparam int IW = $clog2(N);
    localparam logic [N-1:0] ONE = N'(1);

    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) begin
                found   = 1'b1;
                win_idx = IW'(i);
            end
        end
    end

    assign vec = vbase + VW'(win_idx);

    AST_WINNER_PENDING: assert property (@(posedge clk) disable iff (rst)
        found |-> pend[win_idx]); // R8

    AST_NONE_ABOVE: assert property (@(posedge clk) disable iff (rst)
        found |-> ((pend & ((ONE << win_idx) - ONE)) == '0)); // R8

endmodule

// File: rtl/ivc_top.sv
module ivc_top
    import ivc_pkg::*;
#(
    parameter int N  = 32,
    parameter int VW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  irq_in,
    input  logic [2:0]    bus_addr,
    input  logic          bus_we,
    input  logic [N-1:0]  bus_wdata,
    output logic [N-1:0]  bus_rdata,
    output logic          irq_crit,
    output logic          irq_norm,
    output logic          vec_valid,
    output logic [VW-1:0] vec_code
);
    localparam int IW = $clog2(N);

    logic [N-1:0]  active, rise, status, clr;
    logic [N-1:0]  en_io, crit_io, pol_io, trig_io, pend;
    logic [VW-1:0] vbase;
    logic          found;
    logic [IW-1:0] win_idx;

    ivc_input_stage #(.N(N)) u_in (
        .clk(clk), .rst(rst), .pin(irq_in), .pol_hi(pol_io),
        .active(active), .rise(rise)
    );

    ivc_status #(.N(N)) u_st (
        .clk(clk), .rst(rst), .active(active), .rise(rise),
        .edge_mode(trig_io), .clr(clr), .status(status)
    );

    ivc_regfile #(.N(N), .VW(VW)) u_rf (
        .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we),
        .wdata(bus_wdata), .rdata(bus_rdata), .status_io(status),
        .clr_io(clr), .en_io(en_io), .crit_io(crit_io),
        .pol_io(pol_io), .trig_io(trig_io), .vbase(vbase)
    );

    assign pend     = status & en_io;
    assign irq_crit = |(pend & crit_io);
    assign irq_norm = |(pend & ~crit_io);

    ivc_prio #(.N(N), .VW(VW)) u_pr (
        .clk(clk), .rst(rst), .pend(pend), .vbase(vbase),
        .found(found), .win_idx(win_idx), .vec(vec_code)
    );

    assign vec_valid = found;

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (en_io == '0) |-> (!irq_crit && !irq_norm)); // R6

    AST_WIN_CRIT: assert property (@(posedge clk) disable iff (rst)
        (found && crit_io[win_idx]) |-> irq_crit); // R7

    AST_WIN_NORM: assert property (@(posedge clk) disable iff (rst)
        (found && !crit_io[win_idx]) |-> irq_norm); // R7

    AST_VALID_MATCH: assert property (@(posedge clk) disable iff (rst)
        vec_valid == (irq_crit || irq_norm)); // R8

endmodule

// File: tb/ivc_top_bench.sv
module ivc_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] irq_in = '0;
    logic [2:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_crit, irq_norm, vec_valid;
    logic [7:0]  vec_code;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    localparam logic [7:0] BASE = 8'h40;

    always #10 clk = ~clk;

    ivc_top u_ivc_top (
        .clk(clk), .rst(rst), .irq_in(irq_in), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_crit(irq_crit), .irq_norm(irq_norm), .vec_valid(vec_valid),
        .vec_code(vec_code)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] bitof(input int i);
        return 32'h1 << (31 - i);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(3'd0, d); chk("R1 status", d, 32'h0);
        rd(3'd1, d); chk("R1 enable", d, 32'h0);
        rd(3'd2, d); chk("R1 crit", d, 32'h0);
        rd(3'd3, d); chk("R1 pol", d, 32'hFFFF_FFFF);
        rd(3'd4, d); chk("R1 trig", d, 32'h0);
        rd(3'd5, d); chk("R1 vbase", d, 32'h0);
        chk("R1 outputs", {29'd0, irq_crit, irq_norm, vec_valid}, 32'h0);

        wr(3'd5, {24'd0, BASE});

        // R2 R4 R6: bit order, level latency, masking, per-input enable
        for (int i = 0; i < 32; i++) begin
            irq_in[i] = 1'b1;
            wait_cyc(2);
            rd(3'd0, d); chk("R4 not yet", d, 32'h0);
            wait_cyc(1);
            rd(3'd0, d); chk("R2 status bit", d, bitof(i));
            chk("R6 masked", {30'd0, irq_crit, irq_norm}, 32'h0);
            wr(3'd1, bitof(i));
            chk("R2 enable bit", {31'd0, irq_norm}, 32'h1);
            chk("R8 vector", {24'd0, vec_code}, {24'd0, BASE + 8'(i)});
            wr(3'd1, ~bitof(i));
            chk("R2 other enables", {30'd0, irq_crit, irq_norm}, 32'h0);
            wr(3'd1, 32'h0);
            irq_in[i] = 1'b0;
            wait_cyc(3);
            rd(3'd0, d); chk("R4 level release", d, 32'h0);
        end

        // R7 R8 priority sweep, crit on even inputs (reg bits 31-i odd)
        wr(3'd1, 32'hFFFF_FFFF);
        wr(3'd2, 32'hAAAA_AAAA);
        for (int i = 31; i >= 0; i--) begin
            irq_in[i] = 1'b1;
            wait_cyc(3);
            chk("R8 prio vector", {24'd0, vec_code}, {24'd0, BASE + 8'(i)});
            chk("R7 crit", {31'd0, irq_crit}, {31'd0, (i <= 30)});
            chk("R7 norm", {31'd0, irq_norm}, 32'h1);
            chk("R8 valid", {31'd0, vec_valid}, 32'h1);
        end
        irq_in = '0;
        wait_cyc(3);
        chk("R8 idle", {29'd0, irq_crit, irq_norm, vec_valid}, 32'h0);

        // R4 clear has no lasting effect while active
        irq_in[5] = 1'b1;
        wait_cyc(3);
        wr(3'd0, bitof(5));
        wait_cyc(1);
        rd(3'd0, d); chk("R4 clear while active", d, bitof(5));
        irq_in[5] = 1'b0;
        wait_cyc(3);

        // R3 polarity low
        irq_in[9] = 1'b1;
        wr(3'd3, ~bitof(9));
        wait_cyc(4);
        rd(3'd0, d); chk("R3 low-active, pin high", d, 32'h0);
        irq_in[9] = 1'b0;
        wait_cyc(3);
        rd(3'd0, d); chk("R3 low-active, pin low", d, bitof(9));
        chk("R3 request", {31'd0, irq_crit}, 32'h0);
        chk("R3 norm", {31'd0, irq_norm}, 32'h1);
        wr(3'd3, 32'hFFFF_FFFF);
        wait_cyc(3);
        rd(3'd0, d); chk("R3 back to high-active", d, 32'h0);

        // R5 edge mode on input 17
        wr(3'd4, bitof(17));
        irq_in[17] = 1'b1;
        wait_cyc(2);
        irq_in[17] = 1'b0;
        wait_cyc(6);
        rd(3'd0, d); chk("R5 latched", d, bitof(17));
        wr(3'd0, ~bitof(17));
        rd(3'd0, d); chk("R5 write zero keeps", d, bitof(17));
        wr(3'd0, bitof(17));
        rd(3'd0, d); chk("R5 cleared", d, 32'h0);
        irq_in[17] = 1'b1;
        wait_cyc(3);
        rd(3'd0, d); chk("R5 new edge", d, bitof(17));
        chk("R5 vector", {24'd0, vec_code}, {24'd0, BASE + 8'd17});
        wr(3'd0, bitof(17));
        wait_cyc(4);
        rd(3'd0, d); chk("R5 steady high no reset", d, 32'h0);
        irq_in[17] = 1'b0;
        wait_cyc(3);

        // R6 status recorded while disabled, request on enable
        wr(3'd1, 32'h0);
        irq_in[20] = 1'b1;
        irq_in[12] = 1'b1;
        wait_cyc(3);
        chk("R6 all disabled", {30'd0, irq_crit, irq_norm}, 32'h0);
        rd(3'd0, d); chk("R6 status kept", d, bitof(20) | bitof(12));
        wr(3'd1, bitof(20));
        chk("R6 enable one", {24'd0, vec_code}, {24'd0, BASE + 8'd20});
        irq_in = '0;
        wait_cyc(3);

        // R9 unused addresses
        wr(3'd6, 32'hFFFF_FFFF);
        wr(3'd7, 32'hFFFF_FFFF);
        rd(3'd6, d); chk("R9 addr6 reads 0", d, 32'h0);
        rd(3'd7, d); chk("R9 addr7 reads 0", d, 32'h0);
        rd(3'd1, d); chk("R9 enable intact", d, bitof(20));
        rd(3'd2, d); chk("R9 crit intact", d, 32'hAAAA_AAAA);
        rd(3'd4, d); chk("R9 trig intact", d, bitof(17));
        rd(3'd5, d); chk("R9 vbase intact", d, {24'd0, BASE});

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule